// File: doc/BRIEF.md
# Late-Write Pipelined SRAM With Byte Forwarding

This block is an on-chip synchronous memory whose data bus is shared for reads and writes, modelled as a `dataOut` value plus a `driveEn` qualifier. Address and command are registered on every rising clock edge. A read returns its word through an output register one edge after the read is accepted. A write is split in two: the address and command are taken on one edge, and the write data with its byte selects on the following edge. A new command may be accepted on that same data edge.

The newest write stays in holding registers until the data edge of the next write commits it to the array. A read of that held address merges the two sources lane by lane. Lanes that the held write selected come from the holding registers, and the other lanes come from the array. As a result, any command sequence, including a read on the very edge that a write's data arrives, sees the memory as if every earlier write had already completed. The number of byte lanes and the lane width are parameters. The default is four 8-bit lanes, and a two-lane build is a parameter change.

Top module: `late_write_sram`

## Requirements
- R1: After reset, `dataOut` is all zeros and `driveEn` is 0.
- R2: A read (selN=0, writeN=1 at an edge) puts the addressed word on `dataOut` after the next edge. `driveEn` is 1 for that cycle when outEnN=0 and no write was accepted on that next edge.
- R3: With outEnN=1, `driveEn` is 0 in the same cycle. The content of `dataOut` does not change.
- R4: A write command (selN=0, writeN=0 at an edge) takes `dataIn` and `byteSelN` on the following edge. The values on those pins at the command edge have no effect.
- R5: byteSelN[b]=0 enables lane b, which is bits b*BYTE_W up to b*BYTE_W+BYTE_W-1. A lane whose select is 1 keeps its stored value.
- R6: `driveEn` is 0 in the cycle after a write command edge, whatever outEnN is. This holds even when a preceding read's word is in the output register.
- R7: Deselect is pipelined. After a deselect edge, a pending read word is still driven for that cycle, and `driveEn` is 0 after the following edge.
- R8: A read of the newest write's address returns the new data. This includes a read accepted on that write's data edge.
- R9: On such a read, only the lanes that the newest write selected come from the holding registers. The other lanes come from the array.
- R10: A write's data edge commits the previously held write to the array, so reads of the older address return its merged value.
- R11: A command may be accepted on every edge in any mix of reads, writes and idles. Every read matches a model in which writes take effect at their data edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Access select, active low |
| writeN | input | 1 | 0 = write, 1 = read, when selected |
| outEnN | input | 1 | Output enable, active low |
| addr | input | $clog2(DEPTH) | Word address, taken on the command edge |
| byteSelN | input | BYTES | Per-lane write enables, active low, taken on the data edge |
| dataIn | input | BYTES*BYTE_W | Write data, taken on the data edge |
| dataOut | output | BYTES*BYTE_W | Output register contents |
| driveEn | output | 1 | 1 when the block drives the bus |

## Verification
The bench issues reads on the exact data edge of a write to the same address, using partial masks. A design that forwarded whole words, or that forwarded nothing, would return stale or wrongly merged lanes. Back-to-back writes to different addresses, each followed by reads of the older address, expose a design that drops the held write when a newer one replaces it. During each command edge the bench drives deliberately wrong values on `dataIn`, so a design that samples write data one edge early stores them. It also places a read right before a write to show that the read's word is never driven into the write's data cycle, and it checks the exact edge at which deselect and outEnN take the drive away.

// File: rtl/late_write_sram_pkg.sv
package late_write_sram_pkg;
  // Strobes issued by the control to the datapath for the current cycle
  typedef struct packed {
    logic takeCmd;    // capture address on this edge
    logic loadOut;    // load output register (read accepted on last edge)
    logic capData;    // capture write data (write accepted on last edge)
    logic commit;     // retire the held write into the array
    logic holdValid;  // holding registers contain an uncommitted write
  } lw_strobe_t;
endpackage

// File: rtl/late_write_sram_ctrl.sv
module late_write_sram_ctrl
  import late_write_sram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       writeN,
  input  logic       outEnN,
  output lw_strobe_t stb,
  output logic       driveEn
);
  logic rdPend;     // read accepted on the previous edge
  logic wrPend;     // write accepted on the previous edge
  logic driveReg;   // output register holds a read word
  logic holdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend    <= 1'b0;
      wrPend    <= 1'b0;
      driveReg  <= 1'b0;
      holdValid <= 1'b0;
    end else begin
      rdPend   <= !selN && writeN;
      wrPend   <= !selN && !writeN;
      driveReg <= rdPend;
      if (wrPend) holdValid <= 1'b1;
    end
  end

  always_comb begin
    stb.takeCmd   = !selN;
    stb.loadOut   = rdPend;
    stb.capData   = wrPend;
    stb.commit    = wrPend && holdValid;
    stb.holdValid = holdValid;
  end

  // Write data phase forces the bus off irrespective of output enable
  assign driveEn = driveReg && !outEnN && !wrPend;

  // Cycles since reset, saturating; keeps $past windows inside the reset-free span
  logic [1:0] agedCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) agedCnt <= 2'd0;
    else if (agedCnt != 2'd3) agedCnt <= agedCnt + 2'd1;
  end

  // R2
  read_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    (agedCnt >= 2'd2 && $past(!selN && writeN, 2) && !$past(!selN && !writeN) && !outEnN)
      |-> driveEn);

  // R3
  oe_gates_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !driveEn);

  // R6
  write_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !writeN) |=> !driveEn);

  // R7
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (agedCnt >= 2'd2 && $past(selN, 2)) |-> !driveEn);
endmodule

// File: rtl/late_write_sram_dp.sv
module late_write_sram_dp
  import late_write_sram_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  lw_strobe_t       stb,
  input  logic [AW-1:0]    addr,
  input  logic [BYTES-1:0] byteSelN,
  input  logic [DW-1:0]    dataIn,
  output logic [DW-1:0]    dataOut
);
  logic [AW-1:0]    cmdAddr;
  logic [AW-1:0]    holdAddr;
  logic [DW-1:0]    holdData;
  logic [BYTES-1:0] holdMask;
  logic [DW-1:0]    mergedWord;
  logic [DW-1:0]    outReg;
  logic             addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAddr  <= '0;
      holdAddr <= '0;
      holdData <= '0;
      holdMask <= '0;
    end else begin
      if (stb.takeCmd) cmdAddr <= addr;
      if (stb.capData) begin
        holdAddr <= cmdAddr;
        holdData <= dataIn;
        holdMask <= ~byteSelN;
      end
    end
  end

  assign addrHit = stb.holdValid && (holdAddr == cmdAddr);

  // One storage array per byte lane; forwarding decided per lane
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (stb.commit && holdMask[b])
        laneMem[holdAddr] <= holdData[b*BYTE_W +: BYTE_W];
    end

    assign mergedWord[b*BYTE_W +: BYTE_W] =
      (addrHit && holdMask[b]) ? holdData[b*BYTE_W +: BYTE_W] : laneMem[cmdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outReg <= '0;
    else if (stb.loadOut) outReg <= mergedWord;
  end

  assign dataOut = outReg;
endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import late_write_sram_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             writeN,
  input  logic             outEnN,
  input  logic [AW-1:0]    addr,
  input  logic [BYTES-1:0] byteSelN,
  input  logic [DW-1:0]    dataIn,
  output logic [DW-1:0]    dataOut,
  output logic             driveEn
);
  lw_strobe_t stb;

  late_write_sram_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selN    (selN),
    .writeN  (writeN),
    .outEnN  (outEnN),
    .stb     (stb),
    .driveEn (driveEn)
  );

  late_write_sram_dp #(
    .BYTES  (BYTES),
    .BYTE_W (BYTE_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addr     (addr),
    .byteSelN (byteSelN),
    .dataIn   (dataIn),
    .dataOut  (dataOut)
  );
endmodule

// File: tb/late_write_sram_bench.sv
module late_write_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BYTES  = 4;
  localparam int BYTE_W = 8;
  localparam int DEPTH  = 64;
  localparam int AW     = $clog2(DEPTH);
  localparam int DW     = BYTES * BYTE_W;

  logic             clk = 1'b0;
  logic             rstN;
  logic             selN, writeN, outEnN;
  logic [AW-1:0]    addr;
  logic [BYTES-1:0] byteSelN;
  logic [DW-1:0]    dataIn;
  logic [DW-1:0]    dataOut;
  logic             driveEn;

  late_write_sram u_late_write_sram (
    .clk(clk), .rstN(rstN), .selN(selN), .writeN(writeN), .outEnN(outEnN),
    .addr(addr), .byteSelN(byteSelN), .dataIn(dataIn),
    .dataOut(dataOut), .driveEn(driveEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [DW-1:0] expData;
    logic        expDrive;
    string       req;
  } item_t;
  item_t sbq[$];

  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares scoreboard items when their output cycle arrives
  always @(negedge clk) begin
    item_t it;
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      it = sbq.pop_front();
      chk(dataOut === it.expData, it.req, dataOut, it.expData);
      chk(driveEn === it.expDrive, it.req, DW'(driveEn), DW'(it.expDrive));
    end
  end

  // Driver state for the late data phase
  bit               prevWr = 1'b0;
  logic [AW-1:0]    prevAddr;
  logic [DW-1:0]    prevData;
  logic [BYTES-1:0] prevMask;

  // kind: 0 idle, 1 read, 2 write; m is active-high lane mask
  task automatic step(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [BYTES-1:0] m, input string req);
    item_t t;
    @(negedge clk); #1;
    if (prevWr) begin
      dataIn   = prevData;
      byteSelN = ~prevMask;
      for (int b = 0; b < BYTES; b++)
        if (prevMask[b]) model[prevAddr][b*BYTE_W +: BYTE_W] = prevData[b*BYTE_W +: BYTE_W];
    end else begin
      // R4: junk on the data pins outside a data phase must be ignored
      dataIn   = ~d ^ {BYTES{8'h5A}};
      byteSelN = '0;
    end
    case (kind)
      1: begin
        selN = 1'b0; writeN = 1'b1; addr = a;
        t.due = cyc + 2; t.expData = model[a]; t.expDrive = 1'b1; t.req = req;
        sbq.push_back(t);
      end
      2: begin
        selN = 1'b0; writeN = 1'b0; addr = a;
        if (sbq.size() > 0 && sbq[sbq.size()-1].due == cyc + 1) begin
          t = sbq.pop_back();
          t.expDrive = 1'b0;   // R6: read word suppressed in write data cycle
          t.req = "R6";
          sbq.push_back(t);
        end
      end
      default: begin
        selN = 1'b1; writeN = 1'b1; addr = ~a;
      end
    endcase
    prevWr   = (kind == 2);
    prevAddr = a;
    prevData = d;
    prevMask = m;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R11 watchdog actual hung expected done");
    finishRun();
  end

  logic [31:0] lfsr = 32'hACE1_1234;
  logic [DW-1:0] heldWord;

  initial begin
    rstN = 1'b0; selN = 1'b1; writeN = 1'b1; outEnN = 1'b0;
    addr = '0; byteSelN = '1; dataIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1
    chk(driveEn === 1'b0, "R1", DW'(driveEn), '0);
    chk(dataOut === '0, "R1", dataOut, '0);

    // R10: back-to-back full writes fill the array, each commits the previous
    for (int i = 0; i < 16; i++)
      step(2, AW'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0101, 4'hF, "R10");
    // R2: back-to-back reads
    for (int i = 0; i < 16; i++) step(1, AW'(i), '0, '0, "R2");
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");

    // R8: full bypass, read accepted on the write's data edge
    step(2, AW'(20), 32'hCAFE_F00D, 4'hF, "R8");
    step(1, AW'(20), '0, '0, "R8");
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");

    // R9: partial bypass, lanes 0 and 2 from hold, others from array
    step(2, AW'(3), 32'hAA11_BB22, 4'b0101, "R9");
    step(1, AW'(3), '0, '0, "R9");
    // R5/R10: older partial write committed by the next write
    step(2, AW'(3), 32'h7700_0000, 4'b1000, "R5");
    step(2, AW'(4), 32'h0000_9988, 4'b0011, "R10");
    step(1, AW'(3), '0, '0, "R10");
    step(1, AW'(4), '0, '0, "R9");
    step(2, AW'(5), 32'h0000_0000, 4'b0000, "R5");
    step(1, AW'(5), '0, '0, "R5");
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");

    // R6: data phase cycle keeps the bus off
    step(2, AW'(6), 32'h6666_0000, 4'b1100, "R6");
    step(0, '0, '0, '0, "");
    chk(driveEn === 1'b0, "R6", DW'(driveEn), '0);
    outEnN = 1'b0;
    // read immediately followed by a write: scoreboard expects no drive
    step(1, AW'(6), '0, '0, "R2");
    step(2, AW'(7), 32'h0000_7777, 4'b0001, "R6");
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");

    // R3: output enable gates drive only
    step(1, AW'(6), '0, '0, "R3");
    heldWord = model[6];
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");
    outEnN = 1'b1; #1;
    chk(driveEn === 1'b0, "R3", DW'(driveEn), '0);
    chk(dataOut === heldWord, "R3", dataOut, heldWord);
    outEnN = 1'b0; #1;
    chk(driveEn === 1'b1, "R3", DW'(driveEn), 1);

    // R7: pipelined deselect
    step(1, AW'(7), '0, '0, "R7");
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");
    chk(driveEn === 1'b0, "R7", DW'(driveEn), '0);

    // R11: random mixed stream over a small address window
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(int'(lfsr[1:0] == 2'd3 ? 2'd1 : lfsr[1:0]), AW'(lfsr[4:2]),
           {lfsr[15:0], lfsr[31:16]} ^ 32'(n), lfsr[11:8], "R11");
    end
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");
    step(0, '0, '0, '0, "");
    chk(sbq.size() == 0, "R11", DW'(sbq.size()), '0);
    finishRun();
  end
endmodule